// File: doc/BRIEF.md
# Bimodal Branch Direction Predictor

This block is a direct-mapped table of per-branch history for an in-order pipeline with five stages. The fetch PC selects one entry through a slice of its word-address bits. Each entry keeps a small saturating counter, a flag marking the slot as belonging to a branch, and a cached target address. In the same cycle as the lookup, the block returns a branch hint, a taken/not-taken guess, the stored target and the next fetch address.

The counter value read at lookup is carried down the pipeline with the instruction. When the branch resolves, the pipeline presents the PC, the carried counter, the real outcome and the resolved target on the update port. The block then writes back the carried counter stepped by one, saturating at both ends, together with the target. The stored value is never read a second time for the update. A combinational flag shows whether the carried guess was wrong.

Top module: `bimodal_bht`

## Requirements
- R1: After reset every entry holds counter 0 and a clear branch flag. Any lookup then returns `lk_is_br`=0, `lk_taken`=0, `lk_ctr`=0 and `lk_next_pc`=`lk_pc`+4.
- R2: `lk_taken` is 1 exactly when the entry's branch flag is set and its counter is at least 2^(CTR_W-1) (2 or 3 for a 2-bit counter). `lk_next_pc` equals `lk_target` when `lk_taken` is 1, and `lk_pc`+4 otherwise.
- R3: When `up_valid` and `up_is_br` are both 1 at a rising edge, the entry selected by `up_pc` takes three values. Its counter becomes `up_ctr`+1 if `up_taken`=1 and `up_ctr`-1 if `up_taken`=0. Its branch flag becomes 1 and its target becomes `up_target`. A lookup sees the new values from the next cycle on.
- R4: The counter saturates: a taken outcome with carried value 3 writes 3, and a not-taken outcome with carried value 0 writes 0.
- R5: When `up_valid`=0 or `up_is_br`=0, no entry changes.
- R6: The written counter depends only on `up_ctr` and `up_taken`, never on the value currently stored in the entry.
- R7: When a lookup and an update select the same entry in one cycle, the lookup returns the value held before the write.
- R8: The entry index is `pc[IDX_W+1:2]`. PCs that differ only in bits 1:0 or in bits above IDX_W+1 share one entry.
- R9: `up_mispredict` is 1 exactly when `up_valid`=1, `up_is_br`=1 and `up_taken` differs from the most significant bit of `up_ctr`. It is combinational.
- R10: A loop branch with repeating outcomes T,T,T,N, starting from counter 0, is seen at lookup with counters 0,1,2,3,2,3,3,3,2,... Once past the first period, it is predicted correctly 3 times in 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears every entry |
| lk_pc | input | PC_W | Fetch PC for lookup |
| lk_is_br | output | 1 | Entry is marked as a branch |
| lk_taken | output | 1 | Predicted taken |
| lk_ctr | output | CTR_W | Counter read, to be carried with the instruction |
| lk_target | output | PC_W | Cached target address |
| lk_next_pc | output | PC_W | Predicted next fetch address |
| up_valid | input | 1 | A resolving instruction is present |
| up_is_br | input | 1 | Resolving instruction is a branch |
| up_pc | input | PC_W | PC of the resolving instruction |
| up_ctr | input | CTR_W | Counter carried from lookup |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_target | input | PC_W | Resolved target |
| up_mispredict | output | 1 | Carried guess differs from outcome |

## Verification
On every cycle, the assertions check four things: a write becomes visible on the next lookup of the same index, an entry without the branch flag falls through to PC+4, a taken guess redirects to the stored target, and the mispredict flag only rises for a resolving branch whose outcome contradicts the carried counter. Other behaviours need the bench's scenarios. These are the reset contents of the whole table, the absence of any change under a suppressed update, old data on a same-cycle read and write, index aliasing, and the loop accuracy of 3 in 4.

// File: rtl/bimodal_bht_pkg.sv
package bimodal_bht_pkg;

    typedef enum logic {
        DIR_NOT_TAKEN = 1'b0,
        DIR_TAKEN     = 1'b1
    } dir_e;

    // Index slice of a PC: word address bits above the byte offset.
    localparam int unsigned IDX_LSB = 2;

endpackage

// File: rtl/bht_index.sv
module bht_index #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 8
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    import bimodal_bht_pkg::*;

    localparam int unsigned HI = IDX_LSB + IDX_W - 1;

    assign idx = pc[HI:IDX_LSB];

    logic unused_pc_bits;
    assign unused_pc_bits = ^{pc[PC_W-1:HI+1], pc[IDX_LSB-1:0]};
endmodule

// File: rtl/bht_counter_step.sv
module bht_counter_step #(
    parameter int unsigned CTR_W = 2
) (
    input  logic [CTR_W-1:0] ctr_in,
    input  logic             taken,
    output logic [CTR_W-1:0] ctr_out
);
    localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};
    localparam logic [CTR_W-1:0] CTR_MIN = '0;

    always_comb begin
        if (taken) begin
            ctr_out = (ctr_in == CTR_MAX) ? CTR_MAX : ctr_in + 1'b1;
        end else begin
            ctr_out = (ctr_in == CTR_MIN) ? CTR_MIN : ctr_in - 1'b1;
        end
    end
endmodule

// File: rtl/bht_table.sv
module bht_table #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 8,
    parameter int unsigned CTR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTR_W-1:0] rd_ctr,
    output logic             rd_is_br,
    output logic [PC_W-1:0]  rd_target,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CTR_W-1:0] wr_ctr,
    input  logic [PC_W-1:0]  wr_target
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [CTR_W-1:0] ctr;
        logic             is_br;
        logic [PC_W-1:0]  target;
    } slot_t;

    slot_t tab_d [DEPTH];
    slot_t tab_q [DEPTH];

    always_comb begin
        tab_d = tab_q;
        if (wr_en) begin
            tab_d[wr_idx] = '{ctr: wr_ctr, is_br: 1'b1, target: wr_target};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tab_q[i] <= '0;
            end
        end else begin
            tab_q <= tab_d;
        end
    end

    // Combinational read of the registered copy: same-index write is not seen.
    assign rd_ctr    = tab_q[rd_idx].ctr;
    assign rd_is_br  = tab_q[rd_idx].is_br;
    assign rd_target = tab_q[rd_idx].target;
endmodule

// File: rtl/bimodal_bht.sv
module bimodal_bht #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 8,
    parameter int unsigned CTR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  lk_pc,
    output logic             lk_is_br,
    output logic             lk_taken,
    output logic [CTR_W-1:0] lk_ctr,
    output logic [PC_W-1:0]  lk_target,
    output logic [PC_W-1:0]  lk_next_pc,
    input  logic             up_valid,
    input  logic             up_is_br,
    input  logic [PC_W-1:0]  up_pc,
    input  logic [CTR_W-1:0] up_ctr,
    input  logic             up_taken,
    input  logic [PC_W-1:0]  up_target,
    output logic             up_mispredict
);
    import bimodal_bht_pkg::*;

    localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] up_idx;
    logic [CTR_W-1:0] up_ctr_next;
    logic             wr_en;
    dir_e             lk_dir;
    dir_e             carried_dir;

    bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_index (
        .pc  (lk_pc),
        .idx (lk_idx)
    );

    bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_up_index (
        .pc  (up_pc),
        .idx (up_idx)
    );

    bht_counter_step #(.CTR_W(CTR_W)) u_step (
        .ctr_in  (up_ctr),
        .taken   (up_taken),
        .ctr_out (up_ctr_next)
    );

    assign wr_en = up_valid && up_is_br;

    bht_table #(.PC_W(PC_W), .IDX_W(IDX_W), .CTR_W(CTR_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (lk_idx),
        .rd_ctr    (lk_ctr),
        .rd_is_br  (lk_is_br),
        .rd_target (lk_target),
        .wr_en     (wr_en),
        .wr_idx    (up_idx),
        .wr_ctr    (up_ctr_next),
        .wr_target (up_target)
    );

    always_comb begin
        lk_dir      = (lk_is_br && lk_ctr[CTR_W-1]) ? DIR_TAKEN : DIR_NOT_TAKEN;
        carried_dir = up_ctr[CTR_W-1] ? DIR_TAKEN : DIR_NOT_TAKEN;
        lk_taken    = (lk_dir == DIR_TAKEN);
        lk_next_pc  = lk_taken ? lk_target : lk_pc + PC_STEP;
        up_mispredict = wr_en && (dir_e'(up_taken) != carried_dir);
    end
endmodule

// File: rtl/bimodal_bht_chk.sv
module bimodal_bht_chk #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 8,
    parameter int unsigned CTR_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PC_W-1:0]  lk_pc,
    input logic             lk_is_br,
    input logic             lk_taken,
    input logic [CTR_W-1:0] lk_ctr,
    input logic [PC_W-1:0]  lk_target,
    input logic [PC_W-1:0]  lk_next_pc,
    input logic             up_valid,
    input logic             up_is_br,
    input logic [PC_W-1:0]  up_pc,
    input logic [CTR_W-1:0] up_ctr,
    input logic             up_taken,
    input logic [PC_W-1:0]  up_target,
    input logic             up_mispredict
);
    localparam int unsigned CMAX = (1 << CTR_W) - 1;

    logic             wr;
    logic [IDX_W-1:0] li, ui;
    logic [CTR_W-1:0] exp_ctr;
    logic             wr_q;
    logic [IDX_W-1:0] idx_q;
    logic [CTR_W-1:0] exp_q;
    logic [PC_W-1:0]  tgt_q;

    assign wr = up_valid && up_is_br;
    assign li = lk_pc[IDX_W+1:2];
    assign ui = up_pc[IDX_W+1:2];

    logic unused_chk;
    assign unused_chk = ^{up_pc[PC_W-1:IDX_W+2], up_pc[1:0]};

    always_comb begin
        if (up_taken) exp_ctr = (int'(up_ctr) == CMAX) ? up_ctr : CTR_W'(int'(up_ctr) + 1);
        else          exp_ctr = (up_ctr == '0) ? up_ctr : CTR_W'(int'(up_ctr) - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= 1'b0;
            idx_q <= '0;
            exp_q <= '0;
            tgt_q <= '0;
        end else begin
            wr_q  <= wr;
            idx_q <= ui;
            exp_q <= exp_ctr;
            tgt_q <= up_target;
        end
    end

    p_writeback_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_q && li == idx_q) |-> (lk_ctr == exp_q && lk_is_br && lk_target == tgt_q));

    p_no_hint_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_is_br |-> (!lk_taken && lk_next_pc == lk_pc + PC_W'(4)));

    p_taken_redirect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_taken |-> (lk_next_pc == lk_target && lk_is_br));

    p_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        up_mispredict |-> (wr && (up_taken != up_ctr[CTR_W-1])));
endmodule

bind bimodal_bht bimodal_bht_chk #(.PC_W(PC_W), .IDX_W(IDX_W), .CTR_W(CTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_is_br(lk_is_br), .lk_taken(lk_taken),
    .lk_ctr(lk_ctr), .lk_target(lk_target), .lk_next_pc(lk_next_pc),
    .up_valid(up_valid), .up_is_br(up_is_br), .up_pc(up_pc), .up_ctr(up_ctr),
    .up_taken(up_taken), .up_target(up_target), .up_mispredict(up_mispredict)
);

// File: tb/bimodal_bht_tb.sv
module bimodal_bht_tb;
    localparam int unsigned PC_W  = 32;
    localparam int unsigned IDX_W = 4;
    localparam int unsigned CTR_W = 2;
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PC_W-1:0]  lk_pc = '0;
    logic             lk_is_br, lk_taken;
    logic [CTR_W-1:0] lk_ctr;
    logic [PC_W-1:0]  lk_target, lk_next_pc;
    logic             up_valid = 1'b0, up_is_br = 1'b0, up_taken = 1'b0;
    logic [PC_W-1:0]  up_pc = '0, up_target = '0;
    logic [CTR_W-1:0] up_ctr = '0;
    logic             up_mispredict;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    bimodal_bht #(.PC_W(PC_W), .IDX_W(IDX_W), .CTR_W(CTR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_is_br(lk_is_br), .lk_taken(lk_taken),
        .lk_ctr(lk_ctr), .lk_target(lk_target), .lk_next_pc(lk_next_pc),
        .up_valid(up_valid), .up_is_br(up_is_br), .up_pc(up_pc), .up_ctr(up_ctr),
        .up_taken(up_taken), .up_target(up_target), .up_mispredict(up_mispredict)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int step(input int c, input bit t);
        if (t) return (c == 3) ? 3 : c + 1;
        return (c == 0) ? 0 : c - 1;
    endfunction

    function automatic logic [31:0] mk_tgt(input int idx, input int c, input bit t);
        return 32'h8000_0000 | (idx << 8) | (c << 4) | int'(t);
    endfunction

    function automatic logic [31:0] pc_of(input int idx);
        return 32'h0000_4000 | (idx << 2);
    endfunction

    task automatic look(input logic [31:0] pc);
        lk_pc = pc;
        #1;
    endtask

    task automatic update(input logic [31:0] pc, input int c, input bit t, input logic [31:0] tgt);
        up_valid = 1'b1; up_is_br = 1'b1; up_pc = pc;
        up_ctr = CTR_W'(c); up_taken = t; up_target = tgt;
        #1;
        @(posedge clk); #1;
        up_valid = 1'b0; up_is_br = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: whole table cleared, high PC bits varied
        for (int i = 0; i < DEPTH; i++) begin
            look(32'h1230_0000 | (i << 2));
            chk("R1 is_br", 32'(lk_is_br), 0);
            chk("R1 taken", 32'(lk_taken), 0);
            chk("R1 ctr", 32'(lk_ctr), 0);
            chk("R1 next_pc", lk_next_pc, lk_pc + 4);
        end

        // R2 R3 R4 R6 R9: every index, carried value and outcome
        for (int i = 0; i < DEPTH; i++) begin
            for (int c = 0; c < 4; c++) begin
                for (int t = 0; t < 2; t++) begin
                    up_valid = 1'b1; up_is_br = 1'b1; up_pc = pc_of(i);
                    up_ctr = CTR_W'(c); up_taken = t[0]; up_target = mk_tgt(i, c, t[0]);
                    #1;
                    chk("R9 mispredict", 32'(up_mispredict), 32'(t[0] != (c >= 2)));
                    @(posedge clk); #1;
                    up_valid = 1'b0; up_is_br = 1'b0;
                    look(pc_of(i));
                    chk("R3 R4 R6 ctr", 32'(lk_ctr), 32'(step(c, t[0])));
                    chk("R3 is_br", 32'(lk_is_br), 1);
                    chk("R3 target", lk_target, mk_tgt(i, c, t[0]));
                    chk("R2 taken", 32'(lk_taken), 32'(step(c, t[0]) >= 2));
                    chk("R2 next_pc", lk_next_pc,
                        (step(c, t[0]) >= 2) ? mk_tgt(i, c, t[0]) : pc_of(i) + 4);
                end
            end
        end

        // R9: non-branch resolve never flags
        up_valid = 1'b1; up_is_br = 1'b0; up_ctr = 2'd3; up_taken = 1'b0; #1;
        chk("R9 non-branch", 32'(up_mispredict), 0);
        up_valid = 1'b0; up_is_br = 1'b1; #1;
        chk("R9 no valid", 32'(up_mispredict), 0);
        up_is_br = 1'b0;

        // R5: suppressed updates leave entry 3 at ctr 3 with its target
        up_pc = pc_of(3); up_ctr = 2'd0; up_taken = 1'b0; up_target = 32'hDEAD_0000;
        up_valid = 1'b1; up_is_br = 1'b0;
        @(posedge clk); #1;
        up_valid = 1'b0; up_is_br = 1'b1;
        @(posedge clk); #1;
        up_is_br = 1'b0;
        look(pc_of(3));
        chk("R5 ctr", 32'(lk_ctr), 3);
        chk("R5 target", lk_target, mk_tgt(3, 3, 1'b1));

        // R7: same-index read during write returns old value
        look(pc_of(5));
        up_valid = 1'b1; up_is_br = 1'b1; up_pc = pc_of(5);
        up_ctr = 2'd0; up_taken = 1'b0; up_target = 32'h0000_7770;
        #1;
        chk("R7 old ctr", 32'(lk_ctr), 3);
        chk("R7 old target", lk_target, mk_tgt(5, 3, 1'b1));
        @(posedge clk); #1;
        up_valid = 1'b0; up_is_br = 1'b0;
        chk("R7 new ctr", 32'(lk_ctr), 0);

        // R8: aliasing across high bits and byte offset (index 9)
        update(32'hABC0_0024, 1, 1'b1, 32'h0000_9990);
        look(32'h0000_0026);
        chk("R8 alias ctr", 32'(lk_ctr), 2);
        chk("R8 alias next_pc", lk_next_pc, 32'h0000_9990);

        // R10: loop branch T,T,T,N from counter 0 at index 12
        update(pc_of(12), 0, 1'b0, 32'h0000_0100);
        begin
            int model = 0;
            int correct = 0;
            for (int k = 0; k < 12; k++) begin
                bit outc;
                bit pred;
                int carried;
                outc = (k % 4) != 3;
                look(pc_of(12));
                chk("R10 ctr sequence", 32'(lk_ctr), 32'(model));
                pred = lk_taken;
                carried = int'(lk_ctr);
                if (k >= 4 && pred == outc) correct++;
                update(pc_of(12), carried, outc, 32'h0000_0100);
                model = step(model, outc);
            end
            chk("R10 steady correct of 8", 32'(correct), 6);
        end

        finish_run();
    end
endmodule